// File: doc/BRIEF.md
# Output Shift Register with Threshold Refill

This block holds one data word in a shift register and hands out groups of 1 to 32 bits on request. Each OUT request names a bit count. The block returns that many bits right-aligned on `outData` in the same cycle. Depending on the direction setting, the bits come from the low end or the high end of the register. The vacated positions fill with zeros. A counter tracks how many bits have been consumed since the last load. It is compared against a programmable refill limit.

Words arrive from a transmit FIFO through a valid/ready read port. A refill can happen in two ways. With automatic refill enabled, the register reloads once the counter has reached the limit: either in the background or inside the next OUT, which then draws its bits from the fresh word. An explicit pull command loads a word on demand. The pull can be made conditional, so that it acts only when the limit has been reached. A blocking pull waits for a word. A non-blocking pull falls back to a scratch value when the FIFO is empty. Instruction decoding and pin driving belong to the surrounding engine.

Top module: `osr_unit`

## Requirements
- R1: After reset, `shiftCount` reads 32 and the register holds zero. With `cfgAutoRefill` low, no FIFO word is taken in an idle cycle (`fifoReady` stays 0).
- R2: With `cfgShiftRight` = 1, an accepted OUT of n bits returns the n least significant register bits in `outData[n-1:0]`, with zeros above. The register then shifts right by n and fills with zeros.
- R3: With `cfgShiftRight` = 0, an accepted OUT of n bits returns the n most significant register bits in `outData[n-1:0]`, where `outData[n-1]` is register bit 31 and bits above are zero. The register then shifts left by n and fills with zeros.
- R4: `outCount` is 5 bits and encodes 1 to 31 directly, with 0 meaning 32.
- R5: An accepted OUT adds n to `shiftCount`, which saturates at 32. An OUT on a fully drained register returns zeros.
- R6: `cfgLimit` is 5 bits, with 0 meaning 32. The limit counts as reached when `shiftCount` is greater than or equal to it.
- R7: With automatic refill enabled and the limit reached, an OUT with `fifoValid` high is accepted. It pops the FIFO (`fifoReady` = 1) and takes its bits from `fifoData`, leaving `shiftCount` = n.
- R8: With automatic refill enabled, the limit reached and `fifoValid` low, an OUT stalls: `outAck` = 0, and both the register and `shiftCount` keep their values.
- R9: With automatic refill enabled, the limit reached, `fifoValid` high and no request, the register loads `fifoData` in that cycle and `shiftCount` becomes 0.
- R10: A pull is considered only in cycles without `outReq`. An unconditional pull with `fifoValid` high pops the FIFO, loads the word, clears `shiftCount` and asserts `pullAck`.
- R11: A pull with `pullIfEmpty` = 1 while the limit is not reached completes with `pullAck` = 1 and takes no word. The register and counter are unchanged.
- R12: A pull with `pullBlock` = 1 that must load while `fifoValid` is low stalls with `pullAck` = 0, and the state is unchanged.
- R13: A pull with `pullBlock` = 0 that must load while `fifoValid` is low loads `scratchWord`, clears `shiftCount` and asserts `pullAck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgShiftRight | input | 1 | 1: take bits from the low end; 0: from the high end |
| cfgAutoRefill | input | 1 | Enables automatic refill at the limit |
| cfgLimit | input | 5 | Refill limit in bits (0 means 32) |
| outReq | input | 1 | OUT request strobe |
| outCount | input | 5 | Bits requested (0 means 32) |
| outAck | output | 1 | OUT accepted this cycle |
| outData | output | 32 | Requested bits, right-aligned |
| pullReq | input | 1 | Explicit pull request |
| pullBlock | input | 1 | Pull waits for a word when the FIFO is empty |
| pullIfEmpty | input | 1 | Pull acts only when the limit is reached |
| pullAck | output | 1 | Pull completed this cycle |
| scratchWord | input | 32 | Fallback word for a non-blocking pull |
| fifoData | input | 32 | FIFO head word |
| fifoValid | input | 1 | FIFO head word is present |
| fifoReady | output | 1 | FIFO pop this cycle |
| shiftCount | output | 6 | Bits consumed since the last load |

## Verification
The assertions check several properties on every cycle: the counter never exceeds 32, a pop happens only against a valid word, OUT and blocking pull stall when no word is available, and the counter advances by exactly the requested count. A conditional pull below the limit is also checked never to take a word. Bit selection in both directions, zero filling and the count and limit encodings can only be shown by the bench. It sweeps every count from 1 to 32 in each direction and compares against arithmetic expectations. It also runs scenarios covering fresh-word sourcing, scratch fallback and background refill.

// File: rtl/osr_pkg.sv
package osr_pkg;
  typedef struct packed {
    logic shiftEn;
    logic srcFresh;
    logic loadFifo;
    logic loadScratch;
  } osrStrobes_t;
endpackage

// File: rtl/osr_ctrl.sv
module osr_ctrl
  import osr_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int SEL_W = $clog2(WORD_W),
  localparam int CNT_W = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgAutoRefill,
  input  logic [SEL_W-1:0] cfgLimit,
  input  logic             outReq,
  input  logic [SEL_W-1:0] outCount,
  input  logic             pullReq,
  input  logic             pullBlock,
  input  logic             pullIfEmpty,
  input  logic             fifoValid,
  output osrStrobes_t      strb,
  output logic             outAck,
  output logic             pullAck,
  output logic             fifoReady,
  output logic [CNT_W-1:0] outBits,
  output logic [CNT_W-1:0] shiftCount
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [CNT_W-1:0] countQ, countD, limitVal, sumBase;
  logic [CNT_W:0]   sum;
  logic             atLimit, refillDue, pullTake;

  // zero field values stand for a full word
  assign limitVal  = (cfgLimit == '0) ? FULL : {1'b0, cfgLimit};
  assign outBits   = (outCount == '0) ? FULL : {1'b0, outCount};
  assign atLimit   = (countQ >= limitVal);
  assign refillDue = cfgAutoRefill & atLimit;
  assign pullTake  = ~pullIfEmpty | atLimit;
  assign sumBase   = refillDue ? '0 : countQ;
  assign sum       = {1'b0, sumBase} + {1'b0, outBits};

  always_comb begin
    strb      = '0;
    outAck    = 1'b0;
    pullAck   = 1'b0;
    fifoReady = 1'b0;
    countD    = countQ;
    if (outReq) begin
      if (!refillDue || fifoValid) begin
        outAck        = 1'b1;
        strb.shiftEn  = 1'b1;
        strb.srcFresh = refillDue;
        fifoReady     = refillDue;
        countD        = (sum > {1'b0, FULL}) ? FULL : sum[CNT_W-1:0];
      end
    end else if (pullReq) begin
      if (!pullTake) begin
        pullAck = 1'b1;
      end else if (fifoValid) begin
        pullAck       = 1'b1;
        fifoReady     = 1'b1;
        strb.loadFifo = 1'b1;
        countD        = '0;
      end else if (!pullBlock) begin
        pullAck          = 1'b1;
        strb.loadScratch = 1'b1;
        countD           = '0;
      end
    end else if (refillDue && fifoValid) begin
      fifoReady     = 1'b1;
      strb.loadFifo = 1'b1;
      countD        = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) countQ <= FULL;
    else       countQ <= countD;
  end

  assign shiftCount = countQ;
endmodule

// File: rtl/osr_datapath.sv
module osr_datapath
  import osr_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int SEL_W = $clog2(WORD_W),
  localparam int CNT_W = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  osrStrobes_t       strb,
  input  logic              cfgShiftRight,
  input  logic [CNT_W-1:0]  outBits,
  input  logic [WORD_W-1:0] fifoData,
  input  logic [WORD_W-1:0] scratchWord,
  output logic [WORD_W-1:0] outData
);
  logic [WORD_W-1:0]   shiftQ, src, remain;
  logic [2*WORD_W-1:0] leftWide, rightWide, maskWide;

  assign src       = strb.srcFresh ? fifoData : shiftQ;
  // double-width shifts keep a full-word shift well defined
  assign leftWide  = {{WORD_W{1'b0}}, src} << outBits;
  assign rightWide = {src, {WORD_W{1'b0}}} >> outBits;
  assign maskWide  = {{WORD_W{1'b0}}, {WORD_W{1'b1}}} << outBits;

  always_comb begin
    if (cfgShiftRight) begin
      outData = src & maskWide[2*WORD_W-1:WORD_W];
      remain  = rightWide[2*WORD_W-1:WORD_W];
    end else begin
      outData = leftWide[2*WORD_W-1:WORD_W];
      remain  = leftWide[WORD_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 shiftQ <= '0;
    else if (strb.loadFifo)    shiftQ <= fifoData;
    else if (strb.loadScratch) shiftQ <= scratchWord;
    else if (strb.shiftEn)     shiftQ <= remain;
  end
endmodule

// File: rtl/osr_unit.sv
module osr_unit
  import osr_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int SEL_W = $clog2(WORD_W),
  localparam int CNT_W = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgShiftRight,
  input  logic              cfgAutoRefill,
  input  logic [SEL_W-1:0]  cfgLimit,
  input  logic              outReq,
  input  logic [SEL_W-1:0]  outCount,
  output logic              outAck,
  output logic [WORD_W-1:0] outData,
  input  logic              pullReq,
  input  logic              pullBlock,
  input  logic              pullIfEmpty,
  output logic              pullAck,
  input  logic [WORD_W-1:0] scratchWord,
  input  logic [WORD_W-1:0] fifoData,
  input  logic              fifoValid,
  output logic              fifoReady,
  output logic [CNT_W-1:0]  shiftCount
);
  osrStrobes_t      strb;
  logic [CNT_W-1:0] outBits;

  osr_ctrl #(.WORD_W(WORD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgAutoRefill(cfgAutoRefill), .cfgLimit(cfgLimit),
    .outReq(outReq), .outCount(outCount), .pullReq(pullReq), .pullBlock(pullBlock),
    .pullIfEmpty(pullIfEmpty), .fifoValid(fifoValid), .strb(strb), .outAck(outAck),
    .pullAck(pullAck), .fifoReady(fifoReady), .outBits(outBits), .shiftCount(shiftCount)
  );

  osr_datapath #(.WORD_W(WORD_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgShiftRight(cfgShiftRight),
    .outBits(outBits), .fifoData(fifoData), .scratchWord(scratchWord), .outData(outData)
  );
endmodule

// File: rtl/osr_unit_chk.sv
module osr_unit_chk #(
  parameter int WORD_W = 32,
  localparam int SEL_W = $clog2(WORD_W),
  localparam int CNT_W = SEL_W + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgAutoRefill,
  input logic [SEL_W-1:0] cfgLimit,
  input logic             outReq,
  input logic [SEL_W-1:0] outCount,
  input logic             outAck,
  input logic             pullReq,
  input logic             pullBlock,
  input logic             pullIfEmpty,
  input logic             pullAck,
  input logic             fifoValid,
  input logic             fifoReady,
  input logic [CNT_W-1:0] shiftCount
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

  logic [CNT_W-1:0] limChk, nChk, advExp;
  logic [CNT_W:0]   advSum;
  logic             reached;

  assign limChk  = (cfgLimit == '0) ? FULL : {1'b0, cfgLimit};
  assign nChk    = (outCount == '0) ? FULL : {1'b0, outCount};
  assign reached = (shiftCount >= limChk);
  assign advSum  = {1'b0, shiftCount} + {1'b0, nChk};
  assign advExp  = (advSum > {1'b0, FULL}) ? FULL : advSum[CNT_W-1:0];

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    shiftCount <= FULL); // R5

  AST_POP_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    fifoReady |-> fifoValid); // R7

  AST_STALL_NO_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (outReq && cfgAutoRefill && reached && !fifoValid) |-> !outAck); // R8

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (outReq && cfgAutoRefill && reached && !fifoValid) |=> $stable(shiftCount)); // R8

  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (outAck && !fifoReady) |=> (shiftCount == $past(advExp))); // R5

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (fifoReady && !outReq) |=> (shiftCount == '0)); // R10

  AST_IFEMPTY_SKIP: assert property (@(posedge clk) disable iff (!rstN)
    (pullReq && !outReq && pullIfEmpty && !reached) |-> (pullAck && !fifoReady)); // R11

  AST_BLOCK_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (pullReq && !outReq && pullBlock && !fifoValid && !(pullIfEmpty && !reached)) |-> !pullAck); // R12
endmodule

bind osr_unit osr_unit_chk #(.WORD_W(WORD_W)) uChk (
  .clk(clk), .rstN(rstN), .cfgAutoRefill(cfgAutoRefill), .cfgLimit(cfgLimit),
  .outReq(outReq), .outCount(outCount), .outAck(outAck), .pullReq(pullReq),
  .pullBlock(pullBlock), .pullIfEmpty(pullIfEmpty), .pullAck(pullAck),
  .fifoValid(fifoValid), .fifoReady(fifoReady), .shiftCount(shiftCount)
);

// File: tb/sim_osr_unit.sv
`timescale 1ns/1ps
module sim_osr_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgShiftRight = 1'b1, cfgAutoRefill = 1'b0;
  logic [4:0]  cfgLimit = '0;
  logic        outReq = 1'b0;
  logic [4:0]  outCount = '0;
  logic        outAck;
  logic [31:0] outData;
  logic        pullReq = 1'b0, pullBlock = 1'b0, pullIfEmpty = 1'b0;
  logic        pullAck;
  logic [31:0] scratchWord = 32'hC0DE_5AFE;
  logic [31:0] fifoData = '0;
  logic        fifoValid = 1'b0;
  logic        fifoReady;
  logic [5:0]  shiftCount;

  int chkTotal = 0, chkFail = 0;
  bit finished = 0;
  logic [31:0] mReg = '0;
  int          mCnt = 32;

  always #4 clk = ~clk;

  osr_unit u0 (.*);

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    chkTotal++;
    if (act != exp) begin
      chkFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] takeBits(logic [31:0] w, int n, bit right);
    longint unsigned lw = longint'(w);
    if (right) return 32'(lw % (64'd1 << n));
    return 32'(lw / (64'd1 << (32 - n)));
  endfunction

  function automatic logic [31:0] restBits(logic [31:0] w, int n, bit right);
    longint unsigned lw = longint'(w);
    if (right) return 32'(lw / (64'd1 << n));
    return 32'(lw * (64'd1 << n));
  endfunction

  // one clock of activity; expectations derived from the requirements
  task automatic step(input bit oReq, input int n, input bit pReq, input bit blk, input bit ife);
    int lim, newCnt;
    bit atLim, due, eOut, ePull, ePop;
    logic [31:0] eData, newReg;
    string tag;
    @(negedge clk);
    outReq = oReq; outCount = 5'(n); pullReq = pReq; pullBlock = blk; pullIfEmpty = ife;
    #1;
    lim = (cfgLimit == 0) ? 32 : int'(cfgLimit);
    atLim = (mCnt >= lim);
    due = cfgAutoRefill && atLim;
    eOut = 0; ePull = 0; ePop = 0; eData = '0; newReg = mReg; newCnt = mCnt;
    tag = "R9";
    if (oReq) begin
      tag = (n == 32) ? "R4" : (cfgShiftRight ? "R2" : "R3");
      if (due && !fifoValid) tag = "R8 R6";
      else begin
        logic [31:0] s;
        int base;
        if (due) tag = "R7 R6";
        s = due ? fifoData : mReg;
        base = due ? 0 : mCnt;
        eOut = 1; ePop = due;
        eData = takeBits(s, n, cfgShiftRight);
        newReg = restBits(s, n, cfgShiftRight);
        newCnt = (base + n > 32) ? 32 : base + n;
        if (mCnt == 32 && !due) tag = "R5";
      end
    end else if (pReq) begin
      if (ife && !atLim) begin ePull = 1; tag = "R11"; end
      else if (fifoValid) begin ePull = 1; ePop = 1; newReg = fifoData; newCnt = 0; tag = "R10"; end
      else if (!blk) begin ePull = 1; newReg = scratchWord; newCnt = 0; tag = "R13"; end
      else tag = "R12";
    end else if (due && fifoValid) begin
      ePop = 1; newReg = fifoData; newCnt = 0;
    end else if (!cfgAutoRefill) tag = "R1";
    chk(tag, "outAck", longint'(outAck), longint'(eOut));
    chk(tag, "pullAck", longint'(pullAck), longint'(ePull));
    chk(tag, "fifoReady", longint'(fifoReady), longint'(ePop));
    if (eOut) chk(tag, "outData", longint'(outData), longint'(eData));
    @(posedge clk);
    #1;
    mReg = newReg; mCnt = newCnt;
    chk(tag, "shiftCount", longint'(shiftCount), longint'(newCnt));
    outReq = 0; pullReq = 0;
    if (ePop) fifoValid = 0;
  endtask

  initial begin
    #(8 * 100000);
    if (!finished) begin
      chkTotal++; chkFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", chkTotal - chkFail, chkTotal);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    chk("R1", "shiftCount after reset", longint'(shiftCount), 32);
    fifoValid = 1; fifoData = 32'h1111_2222;
    step(0, 1, 0, 0, 0);            // R1: idle with refill off takes nothing
    step(1, 8, 0, 0, 0);            // R5: drained register yields zeros

    // R2 R3 R4 R5 R10: every count in both directions
    for (int dir = 1; dir >= 0; dir--) begin
      cfgShiftRight = dir[0];
      for (int n = 1; n <= 32; n++) begin
        fifoValid = 1;
        fifoData = 32'(n * 32'h9E37_79B9 + 32'h0135_7BDF);
        step(0, 1, 1, 1, 0);
        step(1, n, 0, 0, 0);
        if (n < 32) step(1, 32 - n, 0, 0, 0);
        step(1, 5, 0, 0, 0);
      end
    end

    // R6 R7 R8 R9: automatic refill across limits
    cfgShiftRight = 1; cfgAutoRefill = 1;
    foreach (cfgLimitList[i]) begin
      cfgLimit = cfgLimitList[i];
      fifoValid = 1; fifoData = 32'hA5C3_0F96 ^ 32'(i * 32'h0101_0101);
      step(0, 1, 0, 0, 0);
      for (int k = 0; k < 34; k++) step(1, 1, 0, 0, 0);
      fifoValid = 1; fifoData = 32'h7E1D_3B59 + 32'(i);
      step(1, 3, 0, 0, 0);
      step(1, 6, 1, 0, 0);          // R10: pull loses to OUT
    end

    // R11 R10: conditional pull below and at the limit
    cfgAutoRefill = 0; cfgLimit = 5'd16;
    fifoValid = 1; fifoData = 32'hDEAD_BEEF;
    step(0, 1, 1, 1, 0);
    step(1, 4, 0, 0, 0);
    fifoValid = 1; fifoData = 32'h0BAD_F00D;
    step(0, 1, 1, 1, 1);
    step(1, 4, 0, 0, 0);
    step(1, 12, 0, 0, 0);
    step(0, 1, 1, 1, 1);
    step(1, 8, 0, 0, 0);

    // R12 R13: empty FIFO, blocking then non-blocking
    fifoValid = 0;
    step(0, 1, 1, 1, 0);
    step(0, 1, 1, 1, 0);
    step(0, 1, 1, 0, 0);
    step(1, 32, 0, 0, 0);
    cfgShiftRight = 0;
    step(0, 1, 1, 0, 0);
    step(1, 12, 0, 0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", chkTotal - chkFail, chkTotal);
    $finish;
  end

  logic [4:0] cfgLimitList [5] = '{5'd1, 5'd5, 5'd8, 5'd0, 5'd17};
endmodule